// File: doc/BRIEF.md
# DMA Stream Staging FIFO

This block sits inside one DMA stream, between the side that fetches data and the side that delivers it. In FIFO mode, incoming 32-bit words are held in a small first-in first-out store. The destination side is only released once the fill level reaches a programmable threshold. After release it is held open for a whole burst of 1, 4, 8 or 16 beats, and that burst runs as a single unit. The block reports its fill level and a coarse status. A sticky error flag records any write into a full store and any read from an empty one, and the flag can drive an interrupt.

In direct mode the store is bypassed. Each source write goes straight to the destination in the same cycle, as a single beat. A memory-to-memory stream may not run in direct mode, so the memory-to-memory input forces FIFO mode on. The surrounding stream controller supplies all settings as static inputs and owns the bus protocols. No width packing happens here.

Top module: `dma_stage_fifo`

## Requirements
- R1: After reset, fill_o is 0, status_o is 0 (empty), drain_req_o is 0, err_o is 0 and irq_o is 0.
- R2: In FIFO mode, words leave in the order they were written, and rdata_o always shows the oldest stored word.
- R3: fill_o counts the stored words. status_o reads 0 when the store is empty, 2 when all DEPTH words are held, and 1 for any level in between.
- R4: thresh_i selects the release level in quarters of DEPTH: 0 is 1/4, 1 is 1/2, 2 is 3/4 and 3 is full. While no burst is open and fill_o is below that level, drain_req_o stays low. drain_req_o rises one cycle after fill_o reaches that level.
- R5: burst_i selects the burst length: 0 is 1 beat, 1 is 4, 2 is 8 and 3 is 16. Once drain_req_o rises, it stays high for exactly that many rd_i cycles, whatever the fill level does meanwhile, and falls after the last of them.
- R6: Direct mode applies when fifo_mode_i is 0 and m2m_i is 0. In direct mode, rdata_o equals wdata_i and drain_req_o equals wr_i in the same cycle, fill_o stays 0, status_o reads 0 and no error is raised.
- R7: m2m_i set to 1 forces FIFO mode even when fifo_mode_i is 0.
- R8: In FIFO mode, a write while the store is full and no read takes place is dropped. err_o sets on the next cycle, and the stored words and fill_o are unchanged.
- R9: In FIFO mode, a read while the store is empty sets err_o on the next cycle and leaves fill_o at 0.
- R10: err_o stays set until err_clr_i is pulsed, and a new error in the same cycle as the clear wins. irq_o equals err_o gated by err_irq_en_i.
- R11: A read and a write in the same cycle on a full store are both accepted without error, and fill_o stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | 1 selects FIFO mode, 0 selects direct mode |
| m2m_i | input | 1 | Memory-to-memory stream, forces FIFO mode |
| thresh_i | input | 2 | Release level code |
| burst_i | input | 2 | Burst length code |
| err_irq_en_i | input | 1 | Error interrupt enable |
| err_clr_i | input | 1 | Clears the error flag |
| wr_i | input | 1 | Source writes a word |
| wdata_i | input | 32 | Source data |
| rd_i | input | 1 | Destination takes a word |
| rdata_o | output | 32 | Data to destination |
| drain_req_o | output | 1 | Destination side released |
| fill_o | output | 3 | Stored word count |
| status_o | output | 2 | Fill status code |
| err_o | output | 1 | Sticky overflow/underflow flag |
| irq_o | output | 1 | Error interrupt |

## Verification
The hardest state to reach from the ports is a long burst that outlasts the store depth. An 8- or 16-beat burst can only finish without underflow if the source keeps refilling while the destination drains. The bench therefore releases a one-word threshold and then issues a simultaneous write and read on every beat. This holds the level at one, so drain_req_o must stay high for the full count and then re-arm. The full-store read-with-write case is set up the same way, by filling to DEPTH before pairing the two strobes.

// File: rtl/stage_pkg.sv
package stage_pkg;
  typedef enum logic [1:0] {
    ST_EMPTY = 2'd0,
    ST_PART  = 2'd1,
    ST_FULL  = 2'd2
  } fill_state_e;

  function automatic int unsigned thr_words(logic [1:0] code, int unsigned depth);
    return ((int'(code) + 1) * depth) / 4;
  endfunction

  function automatic int unsigned burst_beats(logic [1:0] code);
    return (code == 2'd0) ? 1 : (1 << (int'(code) + 1));
  endfunction
endpackage

// File: rtl/stage_store.sv
module stage_store #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] level_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] lvl_q;
  logic             rd_ok, wr_ok;

  assign rd_ok = rd_i && (lvl_q != '0);
  assign wr_ok = wr_i && ((lvl_q != CNT_W'(DEPTH)) || rd_ok);
  assign ovf_o = wr_i && !wr_ok;
  assign unf_o = rd_i && (lvl_q == '0);

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   lvl_q <= lvl_q + CNT_W'(1);
        2'b01:   lvl_q <= lvl_q - CNT_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wp_q] <= wdata_i;
  end

  assign rdata_o = mem[rp_q];
  assign level_o = lvl_q;

  // R8
  ovf_keeps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && lvl_q == CNT_W'(DEPTH)) |=> (lvl_q == CNT_W'(DEPTH)));
  // R9
  unf_keeps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && lvl_q == '0) |=> (lvl_q == '0));
  // R3
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/stage_drain.sv
module stage_drain #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned MAX_BURST = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned BEAT_W = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] level_i,
  input  logic [1:0]       thresh_i,
  input  logic [1:0]       burst_i,
  input  logic             rd_i,
  output logic             req_o
);
  import stage_pkg::*;

  logic [BEAT_W-1:0] beats_q;
  logic [CNT_W-1:0]  thr_cnt;
  logic [BEAT_W-1:0] blen;
  logic              start;

  assign thr_cnt = CNT_W'(thr_words(thresh_i, DEPTH));
  assign blen    = BEAT_W'(burst_beats(burst_i));
  assign start   = en_i && (beats_q == '0) && (level_i >= thr_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      beats_q <= '0;
    else if (!en_i)                   beats_q <= '0;
    else if (start)                   beats_q <= blen;
    else if (beats_q != '0 && rd_i)   beats_q <= beats_q - BEAT_W'(1);
  end

  assign req_o = (beats_q != '0);

  // R4
  release_at_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(en_i && level_i >= thr_cnt));
  // R5
  burst_ends_on_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(req_o) && $past(en_i)) |-> $past(rd_i));
endmodule

// File: rtl/dma_stage_fifo.sv
module dma_stage_fifo #(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_BURST = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_mode_i,
  input  logic             m2m_i,
  input  logic [1:0]       thresh_i,
  input  logic [1:0]       burst_i,
  input  logic             err_irq_en_i,
  input  logic             err_clr_i,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             rd_i,
  output logic [DW-1:0]    rdata_o,
  output logic             drain_req_o,
  output logic [CNT_W-1:0] fill_o,
  output logic [1:0]       status_o,
  output logic             err_o,
  output logic             irq_o
);
  import stage_pkg::*;

  logic             use_fifo;
  logic [DW-1:0]    st_rdata;
  logic [CNT_W-1:0] st_level;
  logic             st_ovf, st_unf, seq_req, err_q;
  fill_state_e      fs;

  assign use_fifo = fifo_mode_i || m2m_i;

  stage_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i, .rst_ni,
    .wr_i    (use_fifo && wr_i),
    .rd_i    (use_fifo && rd_i),
    .wdata_i,
    .rdata_o (st_rdata),
    .level_o (st_level),
    .ovf_o   (st_ovf),
    .unf_o   (st_unf)
  );

  stage_drain #(.DEPTH(DEPTH), .MAX_BURST(MAX_BURST)) u_drain (
    .clk_i, .rst_ni,
    .en_i     (use_fifo),
    .level_i  (st_level),
    .thresh_i,
    .burst_i,
    .rd_i,
    .req_o    (seq_req)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                err_q <= 1'b0;
    else if (st_ovf || st_unf)  err_q <= 1'b1;
    else if (err_clr_i)         err_q <= 1'b0;
  end

  always_comb begin
    if (!use_fifo || st_level == '0)    fs = ST_EMPTY;
    else if (st_level == CNT_W'(DEPTH)) fs = ST_FULL;
    else                                fs = ST_PART;
  end

  assign rdata_o     = use_fifo ? st_rdata : wdata_i;
  assign drain_req_o = use_fifo ? seq_req : wr_i;
  assign fill_o      = st_level;
  assign status_o    = fs;
  assign err_o       = err_q;
  assign irq_o       = err_q && err_irq_en_i;

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  // R6
  direct_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_fifo |=> $stable(fill_o));
  // R6
  direct_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!use_fifo && !err_o) |=> !err_o);
endmodule

// File: tb/sim_dma_stage_fifo.sv
module sim_dma_stage_fifo;
  logic        clk_i = 0, rst_ni = 0;
  logic        fifo_mode_i = 0, m2m_i = 0, err_irq_en_i = 0, err_clr_i = 0;
  logic [1:0]  thresh_i = 0, burst_i = 0;
  logic        wr_i = 0, rd_i = 0;
  logic [31:0] wdata_i = 0;
  logic [31:0] rdata_o;
  logic        drain_req_o, err_o, irq_o;
  logic [2:0]  fill_o;
  logic [1:0]  status_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  dma_stage_fifo u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic w, logic [31:0] d, logic r);
    @(negedge clk_i);
    wr_i = w; wdata_i = d; rd_i = r;
    @(posedge clk_i); #1;
    wr_i = 0; rd_i = 0;
  endtask

  task automatic flush();
    fifo_mode_i = 1; m2m_i = 0;
    for (int i = 0; i < 8 && fill_o != 0; i++) cyc(0, 0, 1);
    fifo_mode_i = 0; cyc(0, 0, 0);
    err_clr_i = 1; cyc(0, 0, 0); err_clr_i = 0;
    fifo_mode_i = 1;
  endtask

  task automatic t_reset();
    chk("R1 fill", fill_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 req", drain_req_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_order();
    flush(); thresh_i = 3; burst_i = 0;
    for (int i = 0; i < 2; i++) cyc(1, 32'hA0 + i, 0);
    chk("R3 fill 2", fill_o, 2);
    chk("R3 status part", status_o, 1);
    for (int i = 0; i < 2; i++) begin
      chk("R2 head", rdata_o, 32'hA0 + i);
      cyc(0, 0, 1);
    end
    chk("R3 status empty", status_o, 0);
  endtask

  task automatic t_threshold();
    for (int c = 0; c < 4; c++) begin
      flush(); thresh_i = 2'(c); burst_i = 3;
      for (int i = 0; i < c; i++) cyc(1, i, 0);
      cyc(0, 0, 0);
      chk("R4 below thr", drain_req_o, 0);
      cyc(1, 32'h55, 0);
      chk("R4 fill at thr", fill_o, c + 1);
      chk("R4 not yet", drain_req_o, 0);
      cyc(0, 0, 0);
      chk("R4 released", drain_req_o, 1);
    end
  endtask

  task automatic t_burst4();
    flush(); thresh_i = 3; burst_i = 1;
    for (int i = 0; i < 4; i++) cyc(1, 32'hB0 + i, 0);
    chk("R3 status full", status_o, 2);
    cyc(0, 0, 0);
    chk("R5 b4 start", drain_req_o, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R2 burst data", rdata_o, 32'hB0 + i);
      cyc(0, 0, 1);
      chk("R5 b4 req", drain_req_o, (i < 3) ? 1 : 0);
    end
  endtask

  task automatic t_long_burst();
    for (int c = 2; c < 4; c++) begin
      int beats = 1 << (c + 1);
      flush(); thresh_i = 0; burst_i = 2'(c);
      cyc(1, 32'h10, 0);
      cyc(0, 0, 0);
      chk("R5 long start", drain_req_o, 1);
      for (int i = 0; i < beats; i++) begin
        cyc(1, 32'h11 + i, 1);
        if (i == beats - 2) chk("R5 long held", drain_req_o, 1);
      end
      chk("R5 long end", drain_req_o, 0);
      chk("R5 long no err", err_o, 0);
      cyc(0, 0, 0);
      chk("R5 re-arm", drain_req_o, 1);
    end
  endtask

  task automatic t_direct();
    flush(); fifo_mode_i = 0; m2m_i = 0; burst_i = 3;
    @(negedge clk_i); wr_i = 1; wdata_i = 32'hD1EC7; #1;
    chk("R6 pass data", rdata_o, 32'hD1EC7);
    chk("R6 pass req", drain_req_o, 1);
    @(posedge clk_i); #1; wr_i = 0;
    chk("R6 fill", fill_o, 0);
    chk("R6 status", status_o, 0);
    cyc(0, 0, 1);
    chk("R6 no err", err_o, 0);
    fifo_mode_i = 1;
  endtask

  task automatic t_m2m();
    flush(); fifo_mode_i = 0; m2m_i = 1; thresh_i = 0; burst_i = 0;
    cyc(1, 32'h77, 0);
    chk("R7 stored", fill_o, 1);
    cyc(0, 0, 0);
    chk("R7 req", drain_req_o, 1);
    m2m_i = 0; fifo_mode_i = 1;
  endtask

  task automatic t_overflow();
    flush(); thresh_i = 3; burst_i = 0;
    for (int i = 0; i < 4; i++) cyc(1, 32'hC0 + i, 0);
    cyc(1, 32'hEE, 0);
    chk("R8 err", err_o, 1);
    chk("R8 fill", fill_o, 4);
    err_irq_en_i = 0; #1;
    chk("R10 irq off", irq_o, 0);
    err_irq_en_i = 1; #1;
    chk("R10 irq on", irq_o, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R8 kept data", rdata_o, 32'hC0 + i);
      cyc(0, 0, 1);
    end
    chk("R10 sticky", err_o, 1);
    err_clr_i = 1; cyc(0, 0, 1); err_clr_i = 0;
    chk("R10 set wins", err_o, 1);
    err_clr_i = 1; cyc(0, 0, 0); err_clr_i = 0;
    chk("R10 cleared", err_o, 0);
    chk("R10 irq low", irq_o, 0);
    err_irq_en_i = 0;
  endtask

  task automatic t_underflow();
    flush();
    cyc(0, 0, 1);
    chk("R9 err", err_o, 1);
    chk("R9 fill", fill_o, 0);
  endtask

  task automatic t_full_rw();
    flush(); thresh_i = 3; burst_i = 0;
    for (int i = 0; i < 4; i++) cyc(1, 32'hF0 + i, 0);
    cyc(1, 32'hF4, 1);
    chk("R11 no err", err_o, 0);
    chk("R11 fill", fill_o, 4);
    chk("R11 head", rdata_o, 32'hF1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #22 rst_ni = 1;
    #1;
    t_reset();
    t_order();
    t_threshold();
    t_burst4();
    t_long_burst();
    t_direct();
    t_m2m();
    t_overflow();
    t_underflow();
    t_full_rw();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule